// File: doc/BRIEF.md
# Trace Buffer JTAG Register Chain

This block is the debug-side register path of an on-chip trace buffer. A TAP controller outside the block gives it the current 4-bit instruction and the capture, shift and update strobes of the data-register path, plus TDI. The block drives TDO. One instruction loads a 5-bit chain number. A second instruction opens the chain that number selects. Chain 0 is a 40-bit combined data/address/direction register. Through it the debugger reads and writes a small bank of 32-bit configuration and status words. The trace RAM and the capture core are outside the block. The block reaches them through a read address, a read strobe, a write strobe and the configuration outputs.

A read is issued in one scan and its value is collected in the next scan. The value is captured into the data field of the chain at the start of that following scan. A read of the RAM-data address takes the RAM word at the read pointer and then moves the pointer on by one. A host reads the buffer by repeating scans on that address.

Top module: `trace_jtag_regs`

## Requirements
- R1: While the instruction is 0x2, the 5-bit chain-select register shifts from TDI towards TDO, and TDO is its least significant bit. Capture loads the chain number now in force. Update makes the shifted value the chain number in force.
- R2: Reset sets the chain number to 0. It also clears the read pointer, the write pointer, the trigger word, the control word and the read holding value.
- R3: While the instruction is 0xC and the chain number is 0, the access chain is 40 bits. Bits 31:0 hold data, bits 38:32 hold the address and bit 39 holds the direction. The bit shifted in first ends at bit 0, and TDO shows bit 0.
- R4: An update with direction 1 stores the data into the addressed writable register. These are address 5 (read pointer, low pointer bits), 6 (write pointer, low pointer bits), 7 (trigger word, on cfg_trig) and 8 (control word, on cfg_ctrl). During that update cycle core_wr_stb is high with the address and data on core_wr_addr and core_wr_data.
- R5: An update with direction 0 latches the addressed value. The capture of the next access scan loads that value into bits 31:0 and zeros into bits 39:32. Writes do not change the latched value.
- R6: Writes to addresses 0 to 4 and to addresses 9 to 127 change nothing and raise no write strobe. Reads of addresses 9 to 127 return zero.
- R7: A read of address 4 returns ram_rdata for ram_addr equal to the read pointer. It raises ram_rd_stb for the update cycle, and then the read pointer advances by one, going from DEPTH-1 back to 0.
- R8: Reads of any address other than 4 leave the read pointer unchanged.
- R9: With instruction 0xC and a nonzero chain number, and with any instruction other than 0x2 or 0xC, TDO stays 0 and updates change nothing and raise no strobe.
- R10: Address 0 reads the identification constant, 1 the RAM depth, 2 the RAM width, 3 the core_status input, 5 the read pointer and 6 the write pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Active-low TAP reset |
| instr | input | 4 | Current instruction from the TAP |
| capture_dr | input | 1 | Data-register capture strobe |
| shift_dr | input | 1 | Data-register shift strobe |
| update_dr | input | 1 | Data-register update strobe |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out |
| ram_rdata | input | 32 | Trace RAM word at ram_addr |
| core_status | input | 32 | Status word from the buffer core |
| ram_addr | output | PTR_W | Read pointer, used as the RAM read address |
| ram_rd_stb | output | 1 | RAM word consumed this cycle |
| core_wr_stb | output | 1 | Register write accepted this cycle |
| core_wr_addr | output | 7 | Address of the accepted write |
| core_wr_data | output | 32 | Data of the accepted write |
| cfg_wptr | output | PTR_W | Write pointer register |
| cfg_trig | output | 32 | Trigger word register |
| cfg_ctrl | output | 32 | Control word register |

## Verification
The assertions check several rules on every cycle. The chain number and the shift register stay still outside their own strobes. The read pointer stays in range, moves by exactly one wrap-aware step per RAM read, and stays put otherwise. The strobes stay inside their address sets, and TDO stays quiet for foreign instructions or chains. The bench scenarios cover what only a sequence of scans can show. These are the one-scan read latency, the value each address returns, the wrap of a run of RAM reads, and writes to read-only addresses that are lost. They also include a nonzero chain that blocks a write, which later reads bring out.

// File: rtl/trj_pkg.sv
package trj_pkg;
  localparam int IR_W = 4;
  localparam logic [IR_W-1:0] INS_SELECT = 4'h2;
  localparam logic [IR_W-1:0] INS_ACCESS = 4'hC;

  localparam int A_IDENT   = 0;
  localparam int A_DEPTH   = 1;
  localparam int A_WIDTH   = 2;
  localparam int A_STATUS  = 3;
  localparam int A_RAMDATA = 4;
  localparam int A_RDPTR   = 5;
  localparam int A_WRPTR   = 6;
  localparam int A_TRIG    = 7;
  localparam int A_CTRL    = 8;

  function automatic int unsigned ptr_next(int unsigned p, int unsigned depth);
    return (p >= depth - 1) ? 0 : p + 1;
  endfunction

  function automatic logic reg_writable(int unsigned a);
    return (a >= A_RDPTR) && (a <= A_CTRL);
  endfunction
endpackage

// File: rtl/trj_chain_sel.sv
module trj_chain_sel
  import trj_pkg::*;
#(
  parameter int SEL_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IR_W-1:0]  instr,
  input  logic             capture,
  input  logic             shift,
  input  logic             update,
  input  logic             tdi,
  output logic             sel_tdo,
  output logic [SEL_W-1:0] chain_sel
);
  logic             sel_active;
  logic             sel_upd_ev;
  logic [SEL_W-1:0] sel_sr;

  assign sel_active = (instr == INS_SELECT);
  assign sel_upd_ev = sel_active && update;
  assign sel_tdo    = sel_sr[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_sr    <= '0;
      chain_sel <= '0;
    end else begin
      if (sel_active && capture)
        sel_sr <= chain_sel;
      else if (sel_active && shift)
        sel_sr <= {tdi, sel_sr[SEL_W-1:1]};
      if (sel_upd_ev)
        chain_sel <= sel_sr;
    end
  end

  assert_sel_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_upd_ev |=> $stable(chain_sel));
  assert_sel_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sel_upd_ev |=> chain_sel == $past(sel_sr));
endmodule

// File: rtl/trj_access_sr.sv
module trj_access_sr #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 7,
  localparam int SR_W  = DATA_W + ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              capture,
  input  logic              shift,
  input  logic              update,
  input  logic              tdi,
  input  logic [DATA_W-1:0] rd_word,
  output logic              sr_tdo,
  output logic              req_valid,
  output logic              req_write,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_data
);
  logic [SR_W-1:0] sr;
  logic            cap_ev;
  logic            shf_ev;

  assign cap_ev    = active && capture;
  assign shf_ev    = active && shift;
  assign sr_tdo    = sr[0];
  assign req_valid = active && update;
  assign req_write = sr[SR_W-1];
  assign req_addr  = sr[DATA_W +: ADDR_W];
  assign req_data  = sr[DATA_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      sr <= '0;
    else if (cap_ev)
      sr <= {{(ADDR_W + 1){1'b0}}, rd_word};
    else if (shf_ev)
      sr <= {tdi, sr[SR_W-1:1]};
  end

  assert_sr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(cap_ev || shf_ev) |=> $stable(sr));
  assert_cap_hi_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cap_ev |=> (req_addr == '0) && !req_write && (req_data == $past(rd_word)));
endmodule

// File: rtl/trj_reg_bank.sv
module trj_reg_bank
  import trj_pkg::*;
#(
  parameter int          DATA_W   = 32,
  parameter int          ADDR_W   = 7,
  parameter int          DEPTH    = 16,
  parameter int          RAM_W    = 32,
  parameter logic [31:0] ID_VALUE = 32'h3B90_0F0F,
  localparam int         PTR_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  input  logic [DATA_W-1:0] ram_rdata,
  input  logic [DATA_W-1:0] core_status,
  output logic [DATA_W-1:0] rd_word,
  output logic [PTR_W-1:0]  ram_addr,
  output logic              ram_rd_stb,
  output logic              wr_stb,
  output logic [PTR_W-1:0]  cfg_wptr,
  output logic [DATA_W-1:0] cfg_trig,
  output logic [DATA_W-1:0] cfg_ctrl
);
  logic [PTR_W-1:0]  rd_ptr;
  logic [DATA_W-1:0] rd_mux;
  logic              rd_ev;
  int unsigned       addr_i;

  assign addr_i     = 32'(req_addr);
  assign rd_ev      = req_valid && !req_write;
  assign wr_stb     = req_valid && req_write && reg_writable(addr_i);
  assign ram_rd_stb = rd_ev && (addr_i == A_RAMDATA);
  assign ram_addr   = rd_ptr;

  always_comb begin
    case (addr_i)
      A_IDENT:   rd_mux = DATA_W'(ID_VALUE);
      A_DEPTH:   rd_mux = DATA_W'(DEPTH);
      A_WIDTH:   rd_mux = DATA_W'(RAM_W);
      A_STATUS:  rd_mux = core_status;
      A_RAMDATA: rd_mux = ram_rdata;
      A_RDPTR:   rd_mux = DATA_W'(rd_ptr);
      A_WRPTR:   rd_mux = DATA_W'(cfg_wptr);
      A_TRIG:    rd_mux = cfg_trig;
      A_CTRL:    rd_mux = cfg_ctrl;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr   <= '0;
      cfg_wptr <= '0;
      cfg_trig <= '0;
      cfg_ctrl <= '0;
      rd_word  <= '0;
    end else begin
      if (rd_ev)
        rd_word <= rd_mux;
      if (ram_rd_stb)
        rd_ptr <= PTR_W'(ptr_next(32'(rd_ptr), DEPTH));
      if (wr_stb) begin
        case (addr_i)
          A_RDPTR: rd_ptr   <= req_data[PTR_W-1:0];
          A_WRPTR: cfg_wptr <= req_data[PTR_W-1:0];
          A_TRIG:  cfg_trig <= req_data;
          default: cfg_ctrl <= req_data;
        endcase
      end
    end
  end

  assert_ptr_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    32'(rd_ptr) < DEPTH);
  assert_ptr_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ram_rd_stb |=> 32'(rd_ptr) == ptr_next(32'($past(rd_ptr)), DEPTH));
  assert_ptr_still_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(ram_rd_stb || (wr_stb && addr_i == A_RDPTR)) |=> $stable(rd_ptr));
  assert_wr_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> (addr_i >= A_RDPTR) && (addr_i <= A_CTRL) && req_write);
  assert_hold_on_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_ev |=> $stable(rd_word));
endmodule

// File: rtl/trace_jtag_regs.sv
module trace_jtag_regs
  import trj_pkg::*;
#(
  parameter int          DATA_W   = 32,
  parameter int          ADDR_W   = 7,
  parameter int          SEL_W    = 5,
  parameter int          DEPTH    = 16,
  parameter int          RAM_W    = 32,
  parameter logic [31:0] ID_VALUE = 32'h3B90_0F0F,
  localparam int         PTR_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IR_W-1:0]   instr,
  input  logic              capture_dr,
  input  logic              shift_dr,
  input  logic              update_dr,
  input  logic              tdi,
  output logic              tdo,
  input  logic [DATA_W-1:0] ram_rdata,
  input  logic [DATA_W-1:0] core_status,
  output logic [PTR_W-1:0]  ram_addr,
  output logic              ram_rd_stb,
  output logic              core_wr_stb,
  output logic [ADDR_W-1:0] core_wr_addr,
  output logic [DATA_W-1:0] core_wr_data,
  output logic [PTR_W-1:0]  cfg_wptr,
  output logic [DATA_W-1:0] cfg_trig,
  output logic [DATA_W-1:0] cfg_ctrl
);
  logic [SEL_W-1:0]  chain_sel;
  logic              sel_tdo;
  logic              acc_active;
  logic              acc_tdo;
  logic              req_valid;
  logic              req_write;
  logic [DATA_W-1:0] rd_word;

  trj_chain_sel #(.SEL_W(SEL_W)) u_sel (
    .clk(clk), .rst_n(rst_n), .instr(instr),
    .capture(capture_dr), .shift(shift_dr), .update(update_dr), .tdi(tdi),
    .sel_tdo(sel_tdo), .chain_sel(chain_sel)
  );

  assign acc_active = (instr == INS_ACCESS) && (chain_sel == '0);

  trj_access_sr #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .active(acc_active),
    .capture(capture_dr), .shift(shift_dr), .update(update_dr), .tdi(tdi),
    .rd_word(rd_word), .sr_tdo(acc_tdo),
    .req_valid(req_valid), .req_write(req_write),
    .req_addr(core_wr_addr), .req_data(core_wr_data)
  );

  trj_reg_bank #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .DEPTH(DEPTH),
    .RAM_W(RAM_W), .ID_VALUE(ID_VALUE)
  ) u_bank (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write),
    .req_addr(core_wr_addr), .req_data(core_wr_data),
    .ram_rdata(ram_rdata), .core_status(core_status),
    .rd_word(rd_word), .ram_addr(ram_addr), .ram_rd_stb(ram_rd_stb),
    .wr_stb(core_wr_stb), .cfg_wptr(cfg_wptr),
    .cfg_trig(cfg_trig), .cfg_ctrl(cfg_ctrl)
  );

  always_comb begin
    if (instr == INS_SELECT) tdo = sel_tdo;
    else if (acc_active)     tdo = acc_tdo;
    else                     tdo = 1'b0;
  end

  assert_tdo_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(instr == INS_SELECT || instr == INS_ACCESS) |-> !tdo && !core_wr_stb && !ram_rd_stb);
  assert_other_chain_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (instr == INS_ACCESS && chain_sel != '0) |-> !tdo && !core_wr_stb && !ram_rd_stb);
  assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(core_wr_stb && ram_rd_stb));
endmodule

// File: tb/trace_jtag_regs_tb.sv
`timescale 1ns/1ps
module trace_jtag_regs_tb;
  localparam int          DEPTH = 16;
  localparam logic [31:0] IDV   = 32'h3B90_0F0F;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  instr = 4'h0;
  logic        capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0, tdi = 1'b0;
  logic        tdo;
  logic [31:0] ram_rdata, core_status = 32'h0000_0005;
  logic [3:0]  ram_addr, cfg_wptr;
  logic        ram_rd_stb, core_wr_stb;
  logic [6:0]  core_wr_addr;
  logic [31:0] core_wr_data, cfg_trig, cfg_ctrl;

  int total = 0, bad = 0;
  bit done = 0;

  // bench-side model
  logic [3:0]  m_rp = 0, m_wp = 0;
  logic [31:0] m_trig = 0, m_ctrl = 0, m_hold = 0;
  // strobe samples from the update cycle
  logic        s_wr, s_rd;
  logic [6:0]  s_waddr;
  logic [31:0] s_wdata;

  always #2 clk = ~clk;

  function automatic logic [31:0] ram_word(input logic [3:0] p);
    return 32'h5E00_0000 ^ ({28'd0, p} * 32'h0103_0507);
  endfunction
  assign ram_rdata = ram_word(ram_addr);

  trace_jtag_regs u_dut (
    .clk(clk), .rst_n(rst_n), .instr(instr), .capture_dr(capture_dr),
    .shift_dr(shift_dr), .update_dr(update_dr), .tdi(tdi), .tdo(tdo),
    .ram_rdata(ram_rdata), .core_status(core_status), .ram_addr(ram_addr),
    .ram_rd_stb(ram_rd_stb), .core_wr_stb(core_wr_stb), .core_wr_addr(core_wr_addr),
    .core_wr_data(core_wr_data), .cfg_wptr(cfg_wptr), .cfg_trig(cfg_trig),
    .cfg_ctrl(cfg_ctrl)
  );

  task automatic chk(input string tag, input logic [39:0] act, input logic [39:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model_val(input logic [6:0] a);
    case (a)
      7'd0: return IDV;
      7'd1: return DEPTH;
      7'd2: return 32'd32;
      7'd3: return core_status;
      7'd4: return ram_word(m_rp);
      7'd5: return {28'd0, m_rp};
      7'd6: return {28'd0, m_wp};
      7'd7: return m_trig;
      7'd8: return m_ctrl;
      default: return 32'd0;
    endcase
  endfunction

  task automatic scan(input logic [3:0] ir, input logic [39:0] vec, input int n,
                      output logic [39:0] got);
    got = '0;
    @(negedge clk); instr = ir; capture_dr = 1'b1;
    @(negedge clk); capture_dr = 1'b0; shift_dr = 1'b1;
    for (int k = 0; k < n; k++) begin
      tdi = vec[k];
      #1 got[k] = tdo;
      @(negedge clk);
    end
    shift_dr = 1'b0; update_dr = 1'b1;
    #1;
    s_wr = core_wr_stb; s_rd = ram_rd_stb; s_waddr = core_wr_addr; s_wdata = core_wr_data;
    @(negedge clk); update_dr = 1'b0;
  endtask

  // access op on chain 0, checked against the model
  task automatic op(input logic [31:0] d, input logic [6:0] a, input logic w);
    logic [39:0] got;
    logic        e_wr;
    scan(4'hC, {w, a, d}, 40, got);
    chk("R5 captured data of previous read", {8'd0, got[31:0]}, {8'd0, m_hold});
    chk("R5 captured address/direction zero", {32'd0, got[39:32]}, 40'd0);
    e_wr = w && (a >= 7'd5) && (a <= 7'd8);
    chk("R4_R6 write strobe", {39'd0, s_wr}, {39'd0, e_wr});
    chk("R7 RAM read strobe", {39'd0, s_rd}, {39'd0, (!w && a == 7'd4)});
    if (e_wr) chk("R4 strobe addr/data", {1'b0, s_waddr, s_wdata}, {1'b0, a, d});
    if (w) begin
      case (a)
        7'd5: m_rp = d[3:0];
        7'd6: m_wp = d[3:0];
        7'd7: m_trig = d;
        7'd8: m_ctrl = d;
        default: ;
      endcase
    end else begin
      m_hold = model_val(a);
      if (a == 7'd4) m_rp = (m_rp == 4'(DEPTH - 1)) ? 4'd0 : m_rp + 4'd1;
    end
    #1;
    chk("R4 cfg_trig", {8'd0, cfg_trig}, {8'd0, m_trig});
    chk("R4 cfg_ctrl", {8'd0, cfg_ctrl}, {8'd0, m_ctrl});
    chk("R4 cfg_wptr", {36'd0, cfg_wptr}, {36'd0, m_wp});
    chk("R7_R8 ram_addr pointer", {36'd0, ram_addr}, {36'd0, m_rp});
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    m_rp = 0; m_wp = 0; m_trig = 0; m_ctrl = 0; m_hold = 0;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [39:0] g;
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'd31337);
    do_reset();
    #1;
    // R2: reset state
    chk("R2 tdo after reset", {39'd0, tdo}, 40'd0);
    chk("R2 ram_addr after reset", {36'd0, ram_addr}, 40'd0);
    chk("R2 cfg regs after reset", {cfg_wptr, cfg_trig[3:0], cfg_ctrl}, 40'd0);
    scan(4'h2, 40'd0, 5, g);
    chk("R2 chain select captured 0", g, 40'd0);

    // R10: fixed and status values, one scan latency
    op(32'hFFFF_FFFF, 7'd0, 1'b0);
    op(32'd0, 7'd1, 1'b0);
    op(32'd0, 7'd2, 1'b0);
    op(32'd0, 7'd3, 1'b0);
    core_status = 32'hCAFE_0012;
    op(32'd0, 7'd3, 1'b0);
    op(32'd0, 7'd0, 1'b0);

    // R4: writable registers, then read back (R10 for 5 and 6)
    op(32'h1234_5678, 7'd7, 1'b1);
    op(32'h8000_0003, 7'd8, 1'b1);
    op(32'hFFFF_FFF9, 7'd6, 1'b1);
    op(32'd0, 7'd7, 1'b0);
    op(32'd0, 7'd8, 1'b0);
    op(32'd0, 7'd6, 1'b0);

    // R6: read-only and out-of-range addresses ignore writes
    op(32'hDEAD_BEEF, 7'd0, 1'b1);
    op(32'hDEAD_BEEF, 7'd3, 1'b1);
    op(32'hDEAD_BEEF, 7'd4, 1'b1);
    op(32'hDEAD_BEEF, 7'd9, 1'b1);
    op(32'hDEAD_BEEF, 7'd127, 1'b1);
    op(32'd0, 7'd100, 1'b0);
    op(32'd0, 7'd0, 1'b0);

    // R7: RAM reads advance the pointer and wrap
    op(32'd14, 7'd5, 1'b1);
    op(32'd0, 7'd4, 1'b0);
    op(32'd0, 7'd4, 1'b0);
    op(32'd0, 7'd4, 1'b0);
    op(32'd0, 7'd5, 1'b0);
    // R8: other reads keep the pointer
    op(32'd0, 7'd7, 1'b0);
    op(32'd0, 7'd2, 1'b0);
    op(32'd0, 7'd5, 1'b0);

    // R1: select a nonzero chain and read it back
    scan(4'h2, 40'h13, 5, g);
    scan(4'h2, 40'h13, 5, g);
    chk("R1 chain select capture", g, 40'h13);
    // R9: nonzero chain blocks access
    scan(4'hC, {1'b1, 7'd7, 32'h0BAD_0BAD}, 40, g);
    chk("R9 tdo quiet on nonzero chain", g, 40'd0);
    chk("R9 no strobes on nonzero chain", {38'd0, s_wr, s_rd}, 40'd0);
    chk("R9 trig kept", {8'd0, cfg_trig}, {8'd0, m_trig});
    // R9: foreign instruction
    scan(4'hF, {1'b1, 7'd8, 32'h0BAD_0BAD}, 40, g);
    chk("R9 tdo quiet on other instruction", g, 40'd0);
    chk("R9 no strobes on other instruction", {38'd0, s_wr, s_rd}, 40'd0);
    scan(4'h2, 40'h00, 5, g);
    chk("R1 previous chain number seen", g, 40'h13);
    op(32'd0, 7'd7, 1'b0);
    op(32'd0, 7'd8, 1'b0);
    op(32'd0, 7'd0, 1'b0);

    // R3: random mix of reads and writes on chain 0
    for (int i = 0; i < 120; i++) begin
      int unsigned r;
      logic [6:0]  a;
      r = $urandom % 13;
      if (r <= 8) a = 7'(r);
      else if (r <= 10) a = 7'd4;
      else a = 7'(9 + ($urandom % 119));
      if ($urandom % 5 == 0) core_status = $urandom;
      op($urandom, a, 1'($urandom % 2));
    end

    // R2: reset mid-run clears the chain number
    scan(4'h2, 40'h07, 5, g);
    do_reset();
    scan(4'h2, 40'h00, 5, g);
    chk("R2 chain select cleared by reset", g, 40'd0);
    op(32'd0, 7'd5, 1'b0);
    op(32'd0, 7'd0, 1'b0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule